// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places received frames into a circular buffer made of 256-byte pages. Software programs the first page of the ring and the page just past its end. Software also owns a boundary page that marks the oldest frame it has not yet consumed. The block keeps its own current page, which is where the next frame will go. It streams each frame's payload into the buffer starting at byte 4 of that page. When the frame closes, it fills bytes 0 to 3 of the page with a header. The header holds a copy of the frame's status byte, the page number of the next free page, and a 16-bit count equal to the payload length plus 4. Only after the header has been written does the current page move forward.

Frames arrive as a byte stream with valid/ready handshaking. The first byte carries a start marker. The last byte carries an end marker, an intact flag and the status byte. Buffer writes leave on a second valid/ready stream made of a 16-bit address (page, then offset) and a data byte.

Back-pressure works as follows. While a byte is to be stored, the input's ready follows the memory's ready in the same cycle. Bytes that will not be stored are taken at once. During the four header beats, the input is held off. Producers must hold data and markers steady while valid is high and ready is low.

Two conditions stop storage. In monitor mode, frames are checked but never stored. After an overwrite, the block refuses storage until software moves the boundary.

Top module: `rr_ring_mgr`

## Requirements
- R1: Under reset, and after it, the current page equals the programmed ring start page, no buffer write is requested, the halt flag is low and the input is ready.
- R2: The payload bytes of a stored frame are written in arrival order to consecutive addresses. They start at offset 4 of the current page. After offset 255, writing continues at offset 0 of the following ring page. Every write address lies inside the ring.
- R3: After the last payload byte of an intact stored frame, four header bytes are written to offsets 0, 1, 2, 3 of the frame's first page. Offset 0 holds the status byte given with the end marker, offset 1 the link page, offset 2 the low byte of (length + 4), and offset 3 its high byte.
- R4: The link page is the ring page after the page holding the last payload byte. The page after (stop − 1) is the start page. The current page takes the link value in the same cycle that the one-cycle done pulse rises.
- R5: A frame ended with the intact flag low writes no header, leaves the current page unchanged and raises neither the missed nor the overwrite pulse; its pages are reused by the next frame.
- R6: A frame that begins while monitor mode is on is accepted without any buffer write. It produces one missed pulse and leaves the current page unchanged.
- R7: An overwrite occurs when a stored byte at offset 255 has a next ring page equal to the boundary page, or when the last byte's link page equals the boundary page. On an overwrite the byte is still written, storage of the frame stops, and one overwrite pulse and one missed pulse are raised. The halt flag is set in the same cycle as the overwrite pulse, and the current page is unchanged.
- R8: While the halt flag is set, new frames are not stored and each raises a missed pulse. The flag clears one cycle after the boundary input changes value.
- R9: A requested buffer write that is not accepted keeps its address and data stable in the next cycle. No input byte is accepted while header beats are pending.
- R10: Bytes arriving outside a frame (no start marker seen since the last end marker) are accepted and discarded with no write and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pstart_i | input | 8 | First page of the ring |
| pstop_i | input | 8 | Page just past the ring's last page |
| bnry_i | input | 8 | Software boundary page (oldest unread) |
| mon_mode_i | input | 1 | Monitor mode: check frames but never store them (sampled at frame start) |
| rx_valid_i | input | 1 | Input byte valid |
| rx_ready_o | output | 1 | Input byte accepted this cycle when valid |
| rx_data_i | input | 8 | Input byte |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_ok_i | input | 1 | Frame intact (meaningful with end marker) |
| rx_stat_i | input | 8 | Frame status byte (meaningful with end marker) |
| mw_valid_o | output | 1 | Buffer write request |
| mw_ready_i | input | 1 | Buffer accepts the write |
| mw_addr_o | output | 16 | Write address, page in bits 15:8, offset in bits 7:0 |
| mw_data_o | output | 8 | Write data |
| curr_o | output | 8 | Current page for the next frame |
| frame_done_o | output | 1 | One-cycle pulse when a frame is committed |
| missed_o | output | 1 | One-cycle pulse when a frame could not be stored |
| ovw_o | output | 1 | One-cycle pulse on a ring overwrite |
| halt_o | output | 1 | Storage refused until the boundary moves |

## Verification
A wrong write pointer or page-step result shows at once as a write address or data that the scoreboard does not expect. The bench compares every accepted buffer write against an independently built list, so the first bad beat is reported in the cycle it is accepted. A current page or link value that is off shows in header byte 1 and in the next frame's start address within one frame. A bad overwrite decision appears as extra or missing writes near the boundary crossing, followed by wrong pulse counts and a wrong halt flag checked a few cycles after the frame ends.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 4;
  localparam int CNT_W     = 16;

  typedef enum logic [1:0] {
    HB_STATUS = 2'd0,
    HB_LINK   = 2'd1,
    HB_CNT_LO = 2'd2,
    HB_CNT_HI = 2'd3
  } hdr_beat_e;

  typedef struct packed {
    logic [BYTE_W-1:0] status;
    logic [BYTE_W-1:0] link;
    logic [CNT_W-1:0]  count;
  } hdr_t;
endpackage

// File: rtl/rr_page_step.sv
module rr_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0] start_i,
  input  logic [PAGE_W-1:0] stop_i,
  output logic [PAGE_W-1:0] next_o
);
  logic [PAGE_W-1:0] inc;
  assign inc    = page_i + PAGE_W'(1);
  assign next_o = (inc == stop_i) ? start_i : inc;
endmodule

// File: rtl/rr_frame_track.sv
module rr_frame_track
  import rr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] pstart_i,
  input  logic [PAGE_W-1:0] pstop_i,
  input  logic [PAGE_W-1:0] bnry_i,
  input  logic [PAGE_W-1:0] curr_i,
  input  logic              mon_i,
  input  logic              halt_i,
  input  logic              flow_en_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_ok_i,
  output logic              rx_ready_o,
  output logic              pay_valid_o,
  input  logic              pay_ready_i,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic              commit_o,
  output logic [PAGE_W-1:0] link_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              ev_hit_o,
  output logic              ev_miss_o
);
  logic [ADDR_W-1:0] wp_q;
  logic [CNT_W-1:0]  len_q;
  logic              store_q;
  logic              inframe_q;

  logic              cur_store;
  logic              framed;
  logic              acc;
  logic              last_in_page;
  logic              hit;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [PAGE_W-1:0] link;
  logic [CNT_W-1:0]  len_now;

  // A start marker always opens a fresh frame; storage is decided there.
  assign framed    = rx_sof_i || inframe_q;
  assign cur_store = rx_sof_i ? (!mon_i && !halt_i) : (store_q && inframe_q);
  assign cur_addr  = rx_sof_i ? {curr_i, OFF_W'(HDR_BYTES)} : wp_q;

  rr_page_step #(.PAGE_W(PAGE_W)) u_step (
    .page_i  (cur_addr[ADDR_W-1:OFF_W]),
    .start_i (pstart_i),
    .stop_i  (pstop_i),
    .next_o  (link)
  );

  assign last_in_page = &cur_addr[OFF_W-1:0];
  assign nxt_addr     = last_in_page ? {link, OFF_W'(0)} : cur_addr + ADDR_W'(1);
  assign len_now      = rx_sof_i ? CNT_W'(1) : len_q + CNT_W'(1);

  // Stored bytes wait for the buffer; discarded bytes are taken at once.
  assign rx_ready_o  = flow_en_i && (cur_store ? pay_ready_i : 1'b1);
  assign pay_valid_o = flow_en_i && rx_valid_i && cur_store;
  assign pay_addr_o  = cur_addr;
  assign acc         = rx_valid_i && rx_ready_o;

  // Entering the boundary page, or linking to it, would clobber unread data.
  assign hit = cur_store && (link == bnry_i) && (last_in_page || rx_eof_i);

  assign commit_o  = acc && rx_eof_i && framed && cur_store && !hit && rx_ok_i;
  assign ev_hit_o  = acc && hit;
  assign ev_miss_o = acc && rx_eof_i && framed && (!cur_store || hit);
  assign link_o    = link;
  assign count_o   = len_now + CNT_W'(HDR_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q      <= '0;
      len_q     <= '0;
      store_q   <= 1'b0;
      inframe_q <= 1'b0;
    end else if (acc && framed) begin
      wp_q      <= nxt_addr;
      len_q     <= len_now;
      store_q   <= cur_store && !hit;
      inframe_q <= !rx_eof_i;
    end
  end
endmodule

// File: rtl/rr_hdr_writer.sv
module rr_hdr_writer
  import rr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] link_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PAGE_W-1:0] curr_i,
  output logic              busy_o,
  output logic              hv_valid_o,
  input  logic              hv_ready_i,
  output logic [ADDR_W-1:0] hv_addr_o,
  output logic [BYTE_W-1:0] hv_data_o,
  output logic              adv_o,
  output logic [PAGE_W-1:0] link_o
);
  hdr_t      hdr_q;
  hdr_beat_e beat_q;
  logic      busy_q;
  logic      fire;

  assign busy_o     = busy_q;
  assign hv_valid_o = busy_q;
  assign hv_addr_o  = {curr_i, OFF_W'(beat_q)};
  assign fire       = busy_q && hv_ready_i;
  assign adv_o      = fire && (beat_q == HB_CNT_HI);
  assign link_o     = hdr_q.link[PAGE_W-1:0];

  always_comb begin
    unique case (beat_q)
      HB_STATUS: hv_data_o = hdr_q.status;
      HB_LINK:   hv_data_o = hdr_q.link;
      HB_CNT_LO: hv_data_o = hdr_q.count[BYTE_W-1:0];
      default:   hv_data_o = hdr_q.count[CNT_W-1:BYTE_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= HB_STATUS;
      hdr_q  <= '0;
    end else if (start_i) begin
      busy_q       <= 1'b1;
      beat_q       <= HB_STATUS;
      hdr_q.status <= status_i;
      hdr_q.link   <= BYTE_W'(link_i);
      hdr_q.count  <= count_i;
    end else if (fire) begin
      beat_q <= hdr_beat_e'(beat_q + 2'd1);
      if (beat_q == HB_CNT_HI) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rr_ring_mgr.sv
module rr_ring_mgr
  import rr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] pstart_i,
  input  logic [PAGE_W-1:0] pstop_i,
  input  logic [PAGE_W-1:0] bnry_i,
  input  logic              mon_mode_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_ok_i,
  input  logic [7:0]        rx_stat_i,
  output logic              mw_valid_o,
  input  logic              mw_ready_i,
  output logic [ADDR_W-1:0] mw_addr_o,
  output logic [7:0]        mw_data_o,
  output logic [PAGE_W-1:0] curr_o,
  output logic              frame_done_o,
  output logic              missed_o,
  output logic              ovw_o,
  output logic              halt_o
);
  logic [PAGE_W-1:0] curr_q;
  logic [PAGE_W-1:0] bnry_q;
  logic              halt_q;
  logic              done_q;
  logic              miss_q;
  logic              ovw_q;

  logic              busy;
  logic              pay_valid;
  logic [ADDR_W-1:0] pay_addr;
  logic              commit;
  logic [PAGE_W-1:0] trk_link;
  logic [CNT_W-1:0]  trk_count;
  logic              ev_hit;
  logic              ev_miss;
  logic              hv_valid;
  logic [ADDR_W-1:0] hv_addr;
  logic [BYTE_W-1:0] hv_data;
  logic              adv;
  logic [PAGE_W-1:0] hdr_link;

  rr_frame_track #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .pstart_i    (pstart_i),
    .pstop_i     (pstop_i),
    .bnry_i      (bnry_i),
    .curr_i      (curr_q),
    .mon_i       (mon_mode_i),
    .halt_i      (halt_q),
    .flow_en_i   (!busy),
    .rx_valid_i  (rx_valid_i),
    .rx_sof_i    (rx_sof_i),
    .rx_eof_i    (rx_eof_i),
    .rx_ok_i     (rx_ok_i),
    .rx_ready_o  (rx_ready_o),
    .pay_valid_o (pay_valid),
    .pay_ready_i (mw_ready_i),
    .pay_addr_o  (pay_addr),
    .commit_o    (commit),
    .link_o      (trk_link),
    .count_o     (trk_count),
    .ev_hit_o    (ev_hit),
    .ev_miss_o   (ev_miss)
  );

  rr_hdr_writer #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (commit),
    .link_i     (trk_link),
    .status_i   (rx_stat_i),
    .count_i    (trk_count),
    .curr_i     (curr_q),
    .busy_o     (busy),
    .hv_valid_o (hv_valid),
    .hv_ready_i (mw_ready_i),
    .hv_addr_o  (hv_addr),
    .hv_data_o  (hv_data),
    .adv_o      (adv),
    .link_o     (hdr_link)
  );

  // One write port shared by payload and header beats; header owns it when busy.
  assign mw_valid_o = busy ? hv_valid : pay_valid;
  assign mw_addr_o  = busy ? hv_addr  : pay_addr;
  assign mw_data_o  = busy ? hv_data  : rx_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curr_q <= pstart_i;
      bnry_q <= bnry_i;
      halt_q <= 1'b0;
      done_q <= 1'b0;
      miss_q <= 1'b0;
      ovw_q  <= 1'b0;
    end else begin
      bnry_q <= bnry_i;
      done_q <= adv;
      miss_q <= ev_miss;
      ovw_q  <= ev_hit;
      if (adv) curr_q <= hdr_link;
      if (ev_hit)                 halt_q <= 1'b1;
      else if (bnry_i != bnry_q)  halt_q <= 1'b0;
    end
  end

  assign curr_o       = curr_q;
  assign frame_done_o = done_q;
  assign missed_o     = miss_q;
  assign ovw_o        = ovw_q;
  assign halt_o       = halt_q;
endmodule

// File: rtl/rr_ring_mgr_chk.sv
module rr_ring_mgr_chk #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PAGE_W-1:0] pstart_i,
  input logic [PAGE_W-1:0] pstop_i,
  input logic              mw_valid_o,
  input logic              mw_ready_i,
  input logic [ADDR_W-1:0] mw_addr_o,
  input logic [7:0]        mw_data_o,
  input logic [PAGE_W-1:0] curr_o,
  input logic              frame_done_o,
  input logic              ovw_o,
  input logic              halt_o
);
  // R1: reset loads the ring start page
  assert_reset_page_R1: assert property (@(posedge clk)
    !rst_n |=> curr_o == $past(pstart_i));

  // R2: every write falls inside the ring
  assert_addr_in_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid_o |-> (mw_addr_o[ADDR_W-1:OFF_W] >= pstart_i) &&
                   (mw_addr_o[ADDR_W-1:OFF_W] <  pstop_i));

  // R4: the current page moves only together with the done pulse
  assert_curr_moves_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curr_o) |-> frame_done_o);

  // R7: an overwrite pulse comes with the halt flag
  assert_ovw_sets_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_o |-> halt_o);

  // R9: a stalled write holds address and data
  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid_o && !mw_ready_i |=> mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o));
endmodule

bind rr_ring_mgr rr_ring_mgr_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pstart_i     (pstart_i),
  .pstop_i      (pstop_i),
  .mw_valid_o   (mw_valid_o),
  .mw_ready_i   (mw_ready_i),
  .mw_addr_o    (mw_addr_o),
  .mw_data_o    (mw_data_o),
  .curr_o       (curr_o),
  .frame_done_o (frame_done_o),
  .ovw_o        (ovw_o),
  .halt_o       (halt_o)
);

// File: tb/rr_ring_mgr_tb.sv
`timescale 1ns/1ps
module rr_ring_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pstart_i = 8'd2;
  logic [7:0]  pstop_i  = 8'd8;
  logic [7:0]  bnry_i   = 8'd2;
  logic        mon_mode_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o;
  logic [7:0]  rx_data_i = '0;
  logic        rx_sof_i = 1'b0, rx_eof_i = 1'b0, rx_ok_i = 1'b0;
  logic [7:0]  rx_stat_i = '0;
  logic        mw_valid_o;
  logic        mw_ready_i = 1'b1;
  logic [15:0] mw_addr_o;
  logic [7:0]  mw_data_o;
  logic [7:0]  curr_o;
  logic        frame_done_o, missed_o, ovw_o, halt_o;

  always #2.5 clk = ~clk;

  rr_ring_mgr u_dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  bit stall_en = 0;
  logic [24:0] sb_q[$];   // {is_header, addr, data}
  logic [7:0]  mem [0:4095];
  int n_done = 0, n_miss = 0, n_ovw = 0;
  int e_done = 0, e_miss = 0, e_ovw = 0;
  logic [7:0] curr_m = 8'd2;
  bit halt_m = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wrap(input logic [7:0] p);
    return (p + 8'd1 == pstop_i) ? pstart_i : p + 8'd1;
  endfunction

  function automatic logic [7:0] dbyte(input int fid, input int i);
    return 8'((fid * 37 + i * 5 + 1) & 255);
  endfunction

  // memory stall pattern
  always @(negedge clk) mw_ready_i <= stall_en ? (($urandom % 4) != 0) : 1'b1;

  // monitor: scoreboard comparison and pulse counting
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (frame_done_o) n_done++;
      if (missed_o) n_miss++;
      if (ovw_o) n_ovw++;
      if (mw_valid_o && mw_ready_i) begin
        mem[mw_addr_o[11:0]] = mw_data_o;
        if (sb_q.size() == 0) begin
          chk(0, "R2 unexpected write addr", int'(mw_addr_o), -1);
        end else begin
          logic [24:0] e;
          e = sb_q.pop_front();
          chk(mw_addr_o == e[23:8], e[24] ? "R3 header addr" : "R2 payload addr",
              int'(mw_addr_o), int'(e[23:8]));
          chk(mw_data_o == e[7:0], e[24] ? "R3 header data" : "R2 payload data",
              int'(mw_data_o), int'(e[7:0]));
        end
      end
    end
  end

  task automatic send_frame(input int fid, input int len, input bit ok,
                            input logic [7:0] st, input bit mon);
    logic [15:0] a;
    logic [7:0]  lk, lk_last, first_page;
    bit store, act, hitf;
    store = !mon && !halt_m; act = store; hitf = 0;
    first_page = curr_m;
    a = {curr_m, 8'd4};
    lk_last = '0;
    for (int i = 0; i < len; i++) begin
      if (act) begin
        sb_q.push_back({1'b0, a, dbyte(fid, i)});
        lk = wrap(a[15:8]);
        if (i == len - 1) lk_last = lk;
        if (lk == bnry_i && (a[7:0] == 8'hFF || i == len - 1)) begin
          hitf = 1; act = 0; halt_m = 1; e_ovw++;
        end
        a = (a[7:0] == 8'hFF) ? {lk, 8'h00} : a + 16'd1;
      end
    end
    if (store && !hitf && ok) begin
      sb_q.push_back({1'b1, first_page, 8'd0, st});
      sb_q.push_back({1'b1, first_page, 8'd1, lk_last});
      sb_q.push_back({1'b1, first_page, 8'd2, 8'((len + 4) & 255)});
      sb_q.push_back({1'b1, first_page, 8'd3, 8'(((len + 4) >> 8) & 255)});
      e_done++; curr_m = lk_last;
    end else if (!store || hitf) begin
      e_miss++;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      mon_mode_i = mon;
      rx_valid_i = 1; rx_data_i = dbyte(fid, i);
      rx_sof_i = (i == 0); rx_eof_i = (i == len - 1);
      rx_ok_i = ok; rx_stat_i = st;
      #1;
      while (!rx_ready_o) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    rx_valid_i = 0; rx_sof_i = 0; rx_eof_i = 0; mon_mode_i = 0;
    repeat (10) @(negedge clk);
    #2;
  endtask

  task automatic check_state(input string tag);
    chk(curr_o == curr_m, {tag, " current page"}, curr_o, curr_m);
    chk(halt_o == halt_m, {tag, " halt flag"}, halt_o, halt_m);
    chk(n_done == e_done, {tag, " done pulses"}, n_done, e_done);
    chk(n_miss == e_miss, {tag, " missed pulses"}, n_miss, e_miss);
    chk(n_ovw == e_ovw, {tag, " overwrite pulses"}, n_ovw, e_ovw);
    chk(sb_q.size() == 0, {tag, " pending writes"}, sb_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    // R1: reset state
    chk(curr_o == 8'd2, "R1 current page in reset", curr_o, 2);
    chk(mw_valid_o == 0, "R1 no write in reset", mw_valid_o, 0);
    chk(halt_o == 0, "R1 halt in reset", halt_o, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #2;
    chk(rx_ready_o == 1, "R1 ready after reset", rx_ready_o, 1);
    chk(curr_o == 8'd2, "R1 current page after reset", curr_o, 2);

    // R2 R3 R4: short frame
    send_frame(1, 60, 1, 8'h21, 0);
    check_state("R4 frame1");
    chk(mem[12'h200] == 8'h21, "R3 status byte", mem[12'h200], 8'h21);
    chk(mem[12'h201] == 8'd3, "R3 link byte", mem[12'h201], 3);
    chk(mem[12'h202] == 8'd64, "R3 count low", mem[12'h202], 64);
    chk(mem[12'h203] == 8'd0, "R3 count high", mem[12'h203], 0);

    // R2 R9: multi-page frame under memory stalls
    stall_en = 1;
    send_frame(2, 300, 1, 8'h01, 0);
    check_state("R9 frame2 stalled");
    chk(curr_o == 8'd5, "R4 link after two pages", curr_o, 5);
    chk({mem[12'h303], mem[12'h302]} == 16'd304, "R3 count of 300",
        {mem[12'h303], mem[12'h302]}, 304);
    stall_en = 0;

    // R5: damaged frame
    send_frame(3, 20, 0, 8'h02, 0);
    check_state("R5 damaged frame");

    // R6: monitor mode
    send_frame(4, 30, 1, 8'h01, 1);
    check_state("R6 monitor mode");

    // R4: wrap from last ring page to start page
    @(negedge clk); bnry_i = 8'd4;
    send_frame(5, 700, 1, 8'h01, 0);
    check_state("R4 wrap");
    chk(curr_o == 8'd2, "R4 wrapped to start page", curr_o, 2);

    // R7: overwrite into boundary page
    send_frame(6, 600, 1, 8'h01, 0);
    check_state("R7 overwrite");

    // R8: halted ring refuses storage
    send_frame(7, 10, 1, 8'h01, 0);
    check_state("R8 halted frame");
    @(negedge clk); bnry_i = 8'd5;
    repeat (2) @(negedge clk); #2;
    halt_m = 0;
    chk(halt_o == 0, "R8 halt cleared by boundary move", halt_o, 0);

    // R10: stray byte outside a frame
    @(negedge clk);
    rx_valid_i = 1; rx_data_i = 8'h5A; rx_sof_i = 0; rx_eof_i = 1; rx_ok_i = 1;
    #1;
    chk(rx_ready_o == 1, "R10 stray byte accepted", rx_ready_o, 1);
    @(negedge clk); rx_valid_i = 0; rx_eof_i = 0;
    repeat (4) @(negedge clk); #2;
    check_state("R10 stray byte");

    // R8 R2: storage resumes after clearing
    stall_en = 1;
    send_frame(8, 40, 1, 8'h41, 0);
    check_state("R8 resumed");
    // R3: single-byte frame
    send_frame(9, 1, 1, 8'h81, 0);
    check_state("R3 single byte");
    chk(mem[12'h302] == 8'd5, "R3 count of one byte", mem[12'h302], 5);
    stall_en = 0;

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule